// File: doc/BRIEF.md
# Masked Outer-Product Accumulator Unit

This unit keeps eight architecturally visible accumulators, each a 4×4 matrix of 32-bit signed integers (512 bits). Every instruction names one accumulator and carries two 128-bit source vectors. Each source vector is split into four 32-bit lanes, and every lane holds a short vector of packed signed integers. An update forms the 4×4 outer product of the two sources, where each element is a dot product of a lane of the first source with a lane of the second. It then either adds that product into the chosen accumulator or replaces the accumulator with it.

A row mask, a column mask and a product mask limit which elements are written and which terms are summed. Separate instructions clear an accumulator, load rows into it from a source vector, and read a whole accumulator out. The unit takes one instruction per clock in a two-stage pipeline. Instructions complete in order, so an update to an accumulator that follows directly on another update to the same accumulator sees the earlier result.

Top module: `outer_acc_unit`

## Requirements
- R1: After reset all eight accumulators read as zero and `outValid` is low.
- R2: Op 1 (clear) sets all sixteen elements of the named accumulator to zero, whatever the masks say.
- R3: Op 2 (accumulate) adds to element (i,j) the sum over enabled terms k of A[i][k]·B[j][k]. Lane i is bits 32i+31..32i of a source vector. Element (i,j) sits at bits 32(4i+j)+31..32(4i+j) of `outData`. All terms are signed.
- R4: `inFmt` selects the term width. With 0, each lane holds eight 4-bit terms and term k is at bits 4k+3..4k. With 1, it holds four 8-bit terms at bits 8k+7..8k. With 2, it holds two 16-bit terms at bits 16k+15..16k.
- R5: Bit k of `prodMask` enables term k. Mask bits at or above the rank of the chosen format have no effect.
- R6: Element (i,j) is written only when `rowMask[i]` and `colMask[j]` are both set. Every other element keeps its value.
- R7: Op 3 (overwrite) writes the masked dot product in place of the old element value.
- R8: With `inSat` low, the result wraps modulo 2^32. With `inSat` high, it is clamped to the range -2^31 .. 2^31-1.
- R9: Op 4 (load) copies `srcA` into every row i whose `rowMask[i]` is set. Lane j of `srcA` goes to column j. The other rows are unchanged.
- R10: Op 5 (read) raises `outValid` with the named accumulator on `outData` on the second rising edge after the edge that accepts the instruction. The value read includes every earlier instruction, including updates issued back to back.
- R11: An instruction changes no accumulator other than the one it names. Op 0 and `inValid` low change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | An instruction is present this cycle |
| inOp | input | 3 | 0 none, 1 clear, 2 accumulate, 3 overwrite, 4 load, 5 read |
| inAcc | input | 3 | Accumulator index |
| inFmt | input | 2 | Term width: 0 four-bit, 1 eight-bit, 2 sixteen-bit |
| inSat | input | 1 | Clamp instead of wrap |
| rowMask | input | 4 | Row enables |
| colMask | input | 4 | Column enables |
| prodMask | input | 8 | Term enables |
| srcA | input | 128 | Row source vector, also load data |
| srcB | input | 128 | Column source vector |
| outValid | output | 1 | `outData` holds a read result |
| outData | output | 512 | Accumulator contents |

## Verification
The assertions take for granted that `inOp` only carries codes 0 to 5, and that `inValid` and `inOp` are driven to known values from the first clock. The masked-element and untouched-accumulator properties also depend on the write strobes being mutually exclusive, which the decoder guarantees for legal codes.

The stimulus only ever issues defined opcodes, and uses formats 0 to 2. It holds all inputs at zero throughout reset. Directed sequences exercise saturation at both ends of the range, and random runs draw only legal instruction fields.

// File: rtl/oau_pkg.sv
package oau_pkg;
  localparam int NUM_ACC = 8;
  localparam int DIM     = 4;
  localparam int ELEM_W  = 32;
  localparam int ACC_W   = $clog2(NUM_ACC);
  localparam int NE      = DIM * DIM;

  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_ZERO    = 3'd1,
    OP_GER_ACC = 3'd2,
    OP_GER_OVR = 3'd3,
    OP_MOVEIN  = 3'd4,
    OP_MOVEOUT = 3'd5
  } opCode_t;

  typedef enum logic [1:0] {
    FMT_I4  = 2'd0,
    FMT_I8  = 2'd1,
    FMT_I16 = 2'd2
  } fmt_t;

  typedef struct packed {
    logic             wrZero;
    logic             wrMoveIn;
    logic             wrGer;
    logic             accum;
    logic             sat;
    logic             outStrobe;
    logic [ACC_W-1:0] accSel;
    logic [DIM-1:0]   rowMask;
    logic [NE-1:0]    elemMask;
  } strobes_t;
endpackage

// File: rtl/oau_dot.sv
module oau_dot
  import oau_pkg::*;
#(
  parameter int LANE_W = ELEM_W,
  parameter int MASK_W = LANE_W / 4,
  parameter int DOT_W  = LANE_W + 2
) (
  input  logic [LANE_W-1:0]       a,
  input  logic [LANE_W-1:0]       b,
  input  logic [1:0]              fmt,
  input  logic [MASK_W-1:0]       prodMask,
  output logic signed [DOT_W-1:0] dot
);
  localparam int R4  = LANE_W / 4;
  localparam int R8  = LANE_W / 8;
  localparam int R16 = LANE_W / 16;

  logic signed [DOT_W-1:0] pa, pb, sum;

  always_comb begin
    sum = '0;
    pa  = '0;
    pb  = '0;
    case (fmt_t'(fmt))
      FMT_I4: for (int k = 0; k < R4; k++) begin
        pa = DOT_W'($signed(a[k*4 +: 4]));
        pb = DOT_W'($signed(b[k*4 +: 4]));
        if (prodMask[k]) sum = sum + pa * pb;
      end
      FMT_I8: for (int k = 0; k < R8; k++) begin
        pa = DOT_W'($signed(a[k*8 +: 8]));
        pb = DOT_W'($signed(b[k*8 +: 8]));
        if (prodMask[k]) sum = sum + pa * pb;
      end
      FMT_I16: for (int k = 0; k < R16; k++) begin
        pa = DOT_W'($signed(a[k*16 +: 16]));
        pb = DOT_W'($signed(b[k*16 +: 16]));
        if (prodMask[k]) sum = sum + pa * pb;
      end
      default: sum = '0;
    endcase
    dot = sum;
  end
endmodule

// File: rtl/oau_ctrl.sv
module oau_ctrl
  import oau_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [2:0]       inOp,
  input  logic [ACC_W-1:0] inAcc,
  input  logic             inSat,
  input  logic [DIM-1:0]   rowMask,
  input  logic [DIM-1:0]   colMask,
  output strobes_t         st
);
  strobes_t nextSt;
  opCode_t  op;

  always_comb begin
    op = opCode_t'(inOp);
    nextSt           = '0;
    nextSt.wrZero    = inValid && (op == OP_ZERO);
    nextSt.wrMoveIn  = inValid && (op == OP_MOVEIN);
    nextSt.wrGer     = inValid && ((op == OP_GER_ACC) || (op == OP_GER_OVR));
    nextSt.outStrobe = inValid && (op == OP_MOVEOUT);
    nextSt.accum     = (op == OP_GER_ACC);
    nextSt.sat       = inSat;
    nextSt.accSel    = inAcc;
    nextSt.rowMask   = rowMask;
    for (int e = 0; e < NE; e++)
      nextSt.elemMask[e] = rowMask[e / DIM] & colMask[e % DIM];
  end

  always_ff @(posedge clk) begin
    if (!rstN) st <= '0;
    else       st <= nextSt;
  end

  // R10: at most one action per pipeline slot
  assert_one_action_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.wrZero, st.wrMoveIn, st.wrGer, st.outStrobe}));
endmodule

// File: rtl/oau_dpath.sv
module oau_dpath
  import oau_pkg::*;
#(
  parameter int LANE_W = ELEM_W,
  parameter int MASK_W = LANE_W / 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobes_t              st,
  input  logic [1:0]            inFmt,
  input  logic [MASK_W-1:0]     prodMask,
  input  logic [DIM*LANE_W-1:0] srcA,
  input  logic [DIM*LANE_W-1:0] srcB,
  output logic                  outValid,
  output logic [NE*LANE_W-1:0]  outData
);
  localparam int DOT_W = LANE_W + 2;
  localparam int SUM_W = DOT_W + 1;

  logic signed [DOT_W-1:0] dotNow [NE];
  logic signed [DOT_W-1:0] dotQ   [NE];
  logic [DIM*LANE_W-1:0]   moveQ;
  logic [NE-1:0][LANE_W-1:0] bank [NUM_ACC];
  logic signed [SUM_W-1:0] oldX   [NE];
  logic signed [SUM_W-1:0] sumE   [NE];
  logic [LANE_W-1:0]       resE   [NE];

  for (genvar i = 0; i < DIM; i++) begin : g_row
    for (genvar j = 0; j < DIM; j++) begin : g_col
      oau_dot #(.LANE_W(LANE_W), .MASK_W(MASK_W), .DOT_W(DOT_W)) uDot (
        .a(srcA[i*LANE_W +: LANE_W]), .b(srcB[j*LANE_W +: LANE_W]),
        .fmt(inFmt), .prodMask(prodMask), .dot(dotNow[i*DIM+j]));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      moveQ <= '0;
      for (int e = 0; e < NE; e++) dotQ[e] <= '0;
    end else begin
      moveQ <= srcA;
      for (int e = 0; e < NE; e++) dotQ[e] <= dotNow[e];
    end
  end

  always_comb begin
    for (int e = 0; e < NE; e++) begin
      oldX[e] = st.accum ? SUM_W'($signed(bank[st.accSel][e])) : '0;
      sumE[e] = oldX[e] + SUM_W'(dotQ[e]);
      if (!st.sat || (sumE[e][SUM_W-1:LANE_W-1] == '0) || (sumE[e][SUM_W-1:LANE_W-1] == '1))
        resE[e] = sumE[e][LANE_W-1:0];
      else if (sumE[e][SUM_W-1])
        resE[e] = {1'b1, {(LANE_W-1){1'b0}}};
      else
        resE[e] = {1'b0, {(LANE_W-1){1'b1}}};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int a = 0; a < NUM_ACC; a++) bank[a] <= '0;
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      if (st.wrZero) bank[st.accSel] <= '0;
      if (st.wrMoveIn)
        for (int e = 0; e < NE; e++)
          if (st.rowMask[e / DIM]) bank[st.accSel][e] <= moveQ[(e % DIM)*LANE_W +: LANE_W];
      if (st.wrGer)
        for (int e = 0; e < NE; e++)
          if (st.elemMask[e]) bank[st.accSel][e] <= resE[e];
      outValid <= st.outStrobe;
      if (st.outStrobe) outData <= bank[st.accSel];
    end
  end

  assert_zero_clears_R2: assert property (@(posedge clk) disable iff (!rstN)
    st.wrZero |=> (bank[$past(st.accSel)] == '0));

  for (genvar e = 0; e < NE; e++) begin : g_keep
    assert_masked_keep_R6: assert property (@(posedge clk) disable iff (!rstN)
      (st.wrGer && !st.elemMask[e]) |=>
        (bank[$past(st.accSel)][e] == $past(bank[st.accSel][e])));
  end

  for (genvar a = 0; a < NUM_ACC; a++) begin : g_other
    assert_other_acc_stable_R11: assert property (@(posedge clk) disable iff (!rstN)
      (!(st.wrZero || st.wrMoveIn || st.wrGer) || (st.accSel != ACC_W'(a))) |=>
        $stable(bank[a]));
  end
endmodule

// File: rtl/outer_acc_unit.sv
module outer_acc_unit
  import oau_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           inValid,
  input  logic [2:0]     inOp,
  input  logic [2:0]     inAcc,
  input  logic [1:0]     inFmt,
  input  logic           inSat,
  input  logic [3:0]     rowMask,
  input  logic [3:0]     colMask,
  input  logic [7:0]     prodMask,
  input  logic [127:0]   srcA,
  input  logic [127:0]   srcB,
  output logic           outValid,
  output logic [511:0]   outData
);
  strobes_t st;

  oau_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inOp(inOp), .inAcc(inAcc),
    .inSat(inSat), .rowMask(rowMask), .colMask(colMask), .st(st));

  oau_dpath #(.LANE_W(ELEM_W)) uDpath (
    .clk(clk), .rstN(rstN), .st(st), .inFmt(inFmt), .prodMask(prodMask),
    .srcA(srcA), .srcB(srcB), .outValid(outValid), .outData(outData));

  // R10: a read appears two edges after acceptance
  assert_moveout_latency_R10: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (inOp == 3'd5)) |-> ##2 outValid);

  // R1: no read result without a read instruction two edges earlier
  assert_no_spurious_out_R1: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(st.outStrobe));
endmodule

// File: tb/tb_outer_acc_unit.sv
module tb_outer_acc_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic inValid = 1'b0, inSat = 1'b0;
  logic [2:0] inOp = '0, inAcc = '0;
  logic [1:0] inFmt = '0;
  logic [3:0] rowMask = '0, colMask = '0;
  logic [7:0] prodMask = '0;
  logic [127:0] srcA = '0, srcB = '0;
  logic outValid;
  logic [511:0] outData;

  outer_acc_unit dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [31:0] m [8][16];
  bit p1V = 0, p2V = 0;
  logic [511:0] p1D = '0, p2D = '0;
  string p1T = "R11", p2T = "R11";

  function automatic longint dotRef(input logic [31:0] a, input logic [31:0] b,
                                    input logic [1:0] fmt, input logic [7:0] pm);
    int w, rank;
    longint s, ta, tb;
    s = 0;
    w = (fmt == 2'd0) ? 4 : (fmt == 2'd1) ? 8 : 16;
    rank = 32 / w;
    for (int k = 0; k < rank; k++) begin
      if (pm[k]) begin
        ta = longint'((a >> (k*w)) & ((32'd1 << w) - 1));
        tb = longint'((b >> (k*w)) & ((32'd1 << w) - 1));
        if (ta >= (64'sd1 <<< (w-1))) ta -= (64'sd1 <<< w);
        if (tb >= (64'sd1 <<< (w-1))) tb -= (64'sd1 <<< w);
        s += ta * tb;
      end
    end
    return s;
  endfunction

  task automatic compareOut();
    checks++;
    if (outValid !== p2V || (p2V && outData !== p2D)) begin
      errors++;
      $display("FAIL %s outValid=%0b outData=%h expected outValid=%0b outData=%h",
               p2T, outValid, outData, p2V, p2D);
    end
  endtask

  task automatic issue(input int op, input int acc, input int fmt, input bit sat,
                       input logic [3:0] rm, input logic [3:0] cm, input logic [7:0] pm,
                       input logic [127:0] a, input logic [127:0] b, input string tag);
    longint s, d;
    logic [511:0] snap;
    @(negedge clk);
    compareOut();
    p2V = p1V; p2D = p1D; p2T = p1T;
    inValid = (op != 0); inOp = 3'(op); inAcc = 3'(acc); inFmt = 2'(fmt);
    inSat = sat; rowMask = rm; colMask = cm; prodMask = pm; srcA = a; srcB = b;
    p1V = 0; p1D = '0; p1T = tag;
    case (op)
      1: for (int e = 0; e < 16; e++) m[acc][e] = '0;
      2, 3: for (int i = 0; i < 4; i++) for (int j = 0; j < 4; j++)
        if (rm[i] && cm[j]) begin
          d = dotRef(a[i*32 +: 32], b[j*32 +: 32], 2'(fmt), pm);
          s = (op == 2) ? longint'($signed(m[acc][i*4+j])) + d : d;
          if (sat && s > 64'sd2147483647) s = 64'sd2147483647;
          if (sat && s < -64'sd2147483648) s = -64'sd2147483648;
          m[acc][i*4+j] = 32'(s);
        end
      4: for (int i = 0; i < 4; i++) if (rm[i])
           for (int j = 0; j < 4; j++) m[acc][i*4+j] = a[j*32 +: 32];
      5: begin
        for (int e = 0; e < 16; e++) snap[e*32 +: 32] = m[acc][e];
        p1V = 1; p1D = snap;
      end
      default: ;
    endcase
  endtask

  function automatic logic [127:0] lanes(input logic [31:0] l0, input logic [31:0] l1,
                                         input logic [31:0] l2, input logic [31:0] l3);
    return {l3, l2, l1, l0};
  endfunction

  task automatic readAll(input string tag);
    for (int a = 0; a < 8; a++) issue(5, a, 0, 0, 4'h0, 4'h0, 8'h0, '0, '0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog: actual no completion, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [127:0] va, vb;
    for (int a = 0; a < 8; a++) for (int e = 0; e < 16; e++) m[a][e] = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (outValid !== 1'b0) begin
      errors++;
      $display("FAIL R1 outValid in reset=%0b expected 0", outValid);
    end
    rstN = 1'b1;
    readAll("R1");

    // R9 load rows
    va = lanes(32'h11111111, 32'h22222222, 32'h33333333, 32'h44444444);
    issue(4, 2, 0, 0, 4'hF, 4'h0, 8'h0, va, '0, "R9");
    issue(5, 2, 0, 0, 4'h0, 4'h0, 8'h0, '0, '0, "R9");
    va = lanes(32'hA0A0A0A0, 32'hB1B1B1B1, 32'hC2C2C2C2, 32'hD3D3D3D3);
    issue(4, 2, 0, 0, 4'b0101, 4'h0, 8'h0, va, '0, "R9");
    issue(5, 2, 0, 0, 4'h0, 4'h0, 8'h0, '0, '0, "R9");
    // R2 clear ignores masks
    issue(1, 2, 0, 0, 4'h0, 4'h0, 8'h0, '0, '0, "R2");
    issue(5, 2, 0, 0, 4'h0, 4'h0, 8'h0, '0, '0, "R2");

    // R3 / R10 eight-bit, back-to-back to same accumulator, then read at once
    va = lanes(32'h01FF7F80, 32'h02030405, 32'hFEFDFCFB, 32'h7F7F8080);
    vb = lanes(32'h03020100, 32'hFF01FF01, 32'h80808080, 32'h10F010F0);
    issue(2, 3, 1, 0, 4'hF, 4'hF, 8'h0F, va, vb, "R3");
    issue(2, 3, 1, 0, 4'hF, 4'hF, 8'h0F, va, vb, "R10");
    issue(5, 3, 0, 0, 4'h0, 4'h0, 8'h0, '0, '0, "R10");

    // R4 four-bit and sixteen-bit terms
    va = lanes(32'h7F81F00F, 32'h12345678, 32'h89ABCDEF, 32'h8888FFFF);
    vb = lanes(32'hFEDCBA98, 32'h77777777, 32'h0F0F0F0F, 32'h80017FFF);
    issue(2, 4, 0, 0, 4'hF, 4'hF, 8'hFF, va, vb, "R4");
    issue(5, 4, 0, 0, 4'h0, 4'h0, 8'h0, '0, '0, "R4");
    issue(2, 4, 2, 0, 4'hF, 4'hF, 8'h03, va, vb, "R4");
    issue(5, 4, 0, 0, 4'h0, 4'h0, 8'h0, '0, '0, "R4");

    // R5 term mask, including bits above rank
    issue(2, 5, 1, 0, 4'hF, 4'hF, 8'b0101, va, vb, "R5");
    issue(5, 5, 0, 0, 4'h0, 4'h0, 8'h0, '0, '0, "R5");
    issue(3, 5, 2, 0, 4'hF, 4'hF, 8'hFC, va, vb, "R5");
    issue(5, 5, 0, 0, 4'h0, 4'h0, 8'h0, '0, '0, "R5");

    // R6 row/column masks, R7 overwrite
    issue(2, 3, 1, 0, 4'b1010, 4'b0110, 8'h0F, va, vb, "R6");
    issue(5, 3, 0, 0, 4'h0, 4'h0, 8'h0, '0, '0, "R6");
    issue(3, 3, 0, 0, 4'hF, 4'b0011, 8'hFF, vb, va, "R7");
    issue(5, 3, 0, 0, 4'h0, 4'h0, 8'h0, '0, '0, "R7");

    // R8 wrap and clamp, both directions
    va = {4{32'h7FFFFFF0}};
    vb = {4{32'h00001000}};
    issue(4, 6, 0, 0, 4'hF, 4'h0, 8'h0, va, '0, "R8");
    issue(2, 6, 2, 0, 4'hF, 4'hF, 8'h01, vb, vb, "R8");
    issue(5, 6, 0, 0, 4'h0, 4'h0, 8'h0, '0, '0, "R8");
    issue(4, 6, 0, 0, 4'hF, 4'h0, 8'h0, va, '0, "R8");
    issue(2, 6, 2, 1, 4'hF, 4'hF, 8'h01, vb, vb, "R8");
    issue(5, 6, 0, 0, 4'h0, 4'h0, 8'h0, '0, '0, "R8");
    issue(4, 6, 0, 0, 4'hF, 4'h0, 8'h0, {4{32'h80000010}}, '0, "R8");
    issue(2, 6, 2, 1, 4'hF, 4'hF, 8'h01, vb, {4{32'h0000F000}}, "R8");
    issue(5, 6, 0, 0, 4'h0, 4'h0, 8'h0, '0, '0, "R8");

    // R11 untouched accumulators
    readAll("R11");

    // random mix
    for (int n = 0; n < 600; n++) begin
      va = {$urandom, $urandom, $urandom, $urandom};
      vb = {$urandom, $urandom, $urandom, $urandom};
      issue(int'($urandom % 6), int'($urandom % 8), int'($urandom % 3), 1'($urandom),
            4'($urandom), 4'($urandom), 8'($urandom), va, vb, "R3");
    end
    readAll("R11");
    issue(0, 0, 0, 0, 4'h0, 4'h0, 8'h0, '0, '0, "R11");
    issue(0, 0, 0, 0, 4'h0, 4'h0, 8'h0, '0, '0, "R11");
    issue(0, 0, 0, 0, 4'h0, 4'h0, 8'h0, '0, '0, "R11");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule